// File: doc/BRIEF.md
# Scanline Sprite Composer

This block builds the sprite layer of a tile-and-sprite display one scanline at a time. For each line it clears a line buffer, then walks a table of object descriptors in index order. Every object that covers the line has one pattern row fetched, each 2-bit pixel code mapped through the object's palette, and the result written at the object's horizontal position. Nothing is written for transparent pixels or for pixels past the right screen edge.

Two line buffers alternate. One is being composed while the other, finished on the previous pass, is read out pixel by pixel. The read side returns a colour and a presence flag, and a final selector gives the sprite colour where a sprite pixel exists and the background colour everywhere else. The object table, pattern store and palette contents come from outside. The object table and pattern store are synchronous read memories with one cycle of latency.

Top module: `sprite_line_composer`

## Requirements
- R1: After reset both line buffers are empty: `busy_o` is 0, `hit_o` is 0 and `rgb_o` equals `bg_rgb_i` at every read position.
- R2: Each `line_start_i` pulse swaps the buffers. The read port shows the buffer composed before the most recent pulse, and composition of the new line does not disturb it.
- R3: An object word holds X in bits [31:22], Y in bits [21:13], palette select in bits [12:10] and the pattern address of row 0 in bits [9:0].
- R4: An object is drawn on line v only when 0 <= v - Y <= 15, with no wrap-around. The row read from the pattern store is at address (pattern + v - Y) mod 1024.
- R5: Pixel k of a pattern row is bits [2k+1:2k] and lands at screen x = X + k. Its colour is `pal_table_i[(8*(4*palette + code)) +: 8]`.
- R6: Pixel code 0 is transparent: it neither writes colour nor sets presence, so earlier content shows through.
- R7: Where objects overlap, the one with the higher table index wins.
- R8: Pixels with X + k >= 640 are discarded and never wrap to the left edge.
- R9: Each composition first clears its buffer, so nothing from an earlier use of that buffer survives.
- R10: `rgb_o` is the buffered sprite colour when `hit_o` is 1 and `bg_rgb_i` otherwise. Read positions >= 640 always give `hit_o` = 0.
- R11: `busy_o` rises on the cycle after `line_start_i` and stays high for exactly 160 + 2*512 + H cycles, where H is the number of covering objects. `obj_addr_o` steps through 0..511 in order.
- R12: A `line_start_i` during composition abandons the current line and restarts on the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle pulse: swap buffers and compose `line_i` |
| line_i | input | 9 | Scanline to compose |
| busy_o | output | 1 | Composition in progress |
| obj_addr_o | output | 9 | Object table read address |
| obj_data_i | input | 32 | Object word, one cycle after the address |
| pat_addr_o | output | 10 | Pattern store read address |
| pat_data_i | input | 32 | Pattern row (16 x 2-bit codes), one cycle after the address |
| pal_table_i | input | 256 | 8 palettes x 4 colours x 8 bits |
| rd_x_i | input | 10 | Read position on the finished line |
| bg_rgb_i | input | 8 | Background colour at `rd_x_i` |
| rgb_o | output | 8 | Final pixel colour |
| hit_o | output | 1 | A sprite pixel exists at `rd_x_i` |

## Verification
On every cycle, the assertions check the sequencing: the buffer clear opens every composition, the object address only holds or advances by one, no buffer write happens while the block is idle, and the output selector and right-edge rule hold at the read port. Coverage boundaries, row selection, palette mapping, transparency, overlap priority, edge clipping, buffer swap, clear-on-reuse and restart only show up in the contents of a composed line. The bench reads whole lines back and compares them with a model built from the requirements, using random tables and directed placements.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int unsigned XW     = 10;
  localparam int unsigned YW     = 9;
  localparam int unsigned PW     = 3;
  localparam int unsigned PATW   = 10;
  localparam int unsigned SPR    = 16;
  localparam int unsigned RW     = 4;
  localparam int unsigned COLW   = 8;
  localparam int unsigned PALT_W = (1 << PW) * 4 * COLW;

  typedef struct packed {
    logic [XW-1:0]   x;
    logic [YW-1:0]   y;
    logic [PW-1:0]   pal;
    logic [PATW-1:0] pat;
  } obj_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_FETCH, ST_CHECK, ST_PAT
  } seq_st_e;
endpackage

// File: rtl/spr_seq.sv
module spr_seq
  import spr_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 512,
  parameter int unsigned LINE_W  = 640,
  parameter int unsigned WORDS   = 160,
  localparam int unsigned OAW    = $clog2(NUM_OBJ),
  localparam int unsigned WAW    = $clog2(WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                line_start_i,
  input  logic [YW-1:0]       line_i,
  output logic [OAW-1:0]      obj_addr_o,
  input  logic [31:0]         obj_data_i,
  output logic [PATW-1:0]     pat_addr_o,
  input  logic [2*SPR-1:0]    pat_data_i,
  input  logic [PALT_W-1:0]   pal_table_i,
  output logic                busy_o,
  output logic                draw_sel_o,
  output logic                clr_en_o,
  output logic [WAW-1:0]      clr_idx_o,
  output logic                wr_en_o,
  output logic [XW-1:0]       wr_x_o,
  output logic [SPR-1:0]      wr_mask_o,
  output logic [SPR*COLW-1:0] wr_col_o
);
  localparam logic [OAW-1:0] LAST_OBJ  = OAW'(NUM_OBJ - 1);
  localparam logic [WAW-1:0] LAST_WORD = WAW'(WORDS - 1);

  seq_st_e        st_q;
  logic [OAW-1:0] idx_q;
  logic [WAW-1:0] clr_q;
  logic [YW-1:0]  line_q;
  logic [XW-1:0]  x_q;
  logic [PW-1:0]  pal_q;
  logic           sel_q;

  obj_t       obj;
  logic [YW:0] dy;
  logic        covers;

  assign obj    = obj_t'(obj_data_i);
  assign dy     = {1'b0, line_q} - {1'b0, obj.y};
  assign covers = (dy[YW:RW] == '0);  // also rejects negative offsets

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      clr_q  <= '0;
      line_q <= '0;
      x_q    <= '0;
      pal_q  <= '0;
      sel_q  <= 1'b0;
    end else if (line_start_i) begin
      st_q   <= ST_CLEAR;
      idx_q  <= '0;
      clr_q  <= '0;
      line_q <= line_i;
      sel_q  <= ~sel_q;
    end else begin
      unique case (st_q)
        ST_CLEAR: begin
          if (clr_q == LAST_WORD) st_q <= ST_FETCH;
          else clr_q <= clr_q + 1'b1;
        end
        ST_FETCH: st_q <= ST_CHECK;
        ST_CHECK: begin
          if (covers) begin
            st_q  <= ST_PAT;
            x_q   <= obj.x;
            pal_q <= obj.pal;
          end else if (idx_q == LAST_OBJ) begin
            st_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_FETCH;
          end
        end
        ST_PAT: begin
          if (idx_q == LAST_OBJ) begin
            st_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_FETCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign obj_addr_o = idx_q;
  assign pat_addr_o = obj.pat + PATW'(dy[RW-1:0]);
  assign busy_o     = (st_q != ST_IDLE);
  assign draw_sel_o = sel_q;
  assign clr_en_o   = (st_q == ST_CLEAR);
  assign clr_idx_o  = clr_q;
  assign wr_en_o    = (st_q == ST_PAT);
  assign wr_x_o     = x_q;

  for (genvar k = 0; k < SPR; k++) begin : g_pix
    logic [1:0]  code;
    logic [XW:0] px;
    assign code = pat_data_i[2*k +: 2];
    assign px   = {1'b0, x_q} + (XW+1)'(k);
    assign wr_mask_o[k] = (code != 2'b00) && (px < (XW+1)'(LINE_W));
    assign wr_col_o[k*COLW +: COLW] = pal_table_i[{pal_q, code} * COLW +: COLW];
  end
endmodule

// File: rtl/spr_line_buf.sv
module spr_line_buf
  import spr_pkg::*;
#(
  parameter int unsigned LINE_W  = 640,
  parameter int unsigned WORDS   = 160,
  localparam int unsigned WAW    = $clog2(WORDS),
  localparam int unsigned WORD_W = 4 * (COLW + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                draw_sel_i,
  input  logic                clr_en_i,
  input  logic [WAW-1:0]      clr_idx_i,
  input  logic                wr_en_i,
  input  logic [XW-1:0]       wr_x_i,
  input  logic [SPR-1:0]      wr_mask_i,
  input  logic [SPR*COLW-1:0] wr_col_i,
  input  logic [XW-1:0]       rd_x_i,
  output logic                rd_hit_o,
  output logic [COLW-1:0]     rd_col_o
);
  // lane j of a word: [9j+8] presence, [9j+7:9j] colour
  logic [WORD_W-1:0] mem_q [2][WORDS];
  logic [XW:0]       wpos [SPR];

  for (genvar k = 0; k < SPR; k++) begin : g_pos
    assign wpos[k] = {1'b0, wr_x_i} + (XW+1)'(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < WORDS; w++)
          mem_q[b][w] <= '0;
    end else if (clr_en_i) begin
      mem_q[draw_sel_i][clr_idx_i] <= '0;
    end else if (wr_en_i) begin
      for (int k = 0; k < SPR; k++)
        if (wr_mask_i[k])
          mem_q[draw_sel_i][WAW'(wpos[k] >> 2)][(COLW+1)*wpos[k][1:0] +: COLW+1]
            <= {1'b1, wr_col_i[k*COLW +: COLW]};
    end
  end

  logic              in_range;
  logic [WAW-1:0]    rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic [COLW:0]     rd_ent;

  assign in_range = (rd_x_i < XW'(LINE_W));
  assign rd_idx   = in_range ? WAW'(rd_x_i >> 2) : '0;
  assign rd_word  = mem_q[~draw_sel_i][rd_idx];
  assign rd_ent   = rd_word[(COLW+1)*rd_x_i[1:0] +: COLW+1];
  assign rd_hit_o = in_range & rd_ent[COLW];
  assign rd_col_o = rd_ent[COLW-1:0];
endmodule

// File: rtl/spr_out_mux.sv
module spr_out_mux
  import spr_pkg::*;
(
  input  logic            spr_hit_i,
  input  logic [COLW-1:0] spr_col_i,
  input  logic [COLW-1:0] bg_col_i,
  output logic [COLW-1:0] rgb_o,
  output logic            hit_o
);
  assign rgb_o = spr_hit_i ? spr_col_i : bg_col_i;
  assign hit_o = spr_hit_i;
endmodule

// File: rtl/sprite_line_composer.sv
module sprite_line_composer
  import spr_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 512,
  parameter int unsigned LINE_W  = 640,
  localparam int unsigned OAW    = $clog2(NUM_OBJ),
  localparam int unsigned WORDS  = (LINE_W + 3) / 4,
  localparam int unsigned WAW    = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [YW-1:0]     line_i,
  output logic              busy_o,
  output logic [OAW-1:0]    obj_addr_o,
  input  logic [31:0]       obj_data_i,
  output logic [PATW-1:0]   pat_addr_o,
  input  logic [31:0]       pat_data_i,
  input  logic [PALT_W-1:0] pal_table_i,
  input  logic [XW-1:0]     rd_x_i,
  input  logic [COLW-1:0]   bg_rgb_i,
  output logic [COLW-1:0]   rgb_o,
  output logic              hit_o
);
  logic                draw_sel;
  logic                clr_en;
  logic [WAW-1:0]      clr_idx;
  logic                wr_en;
  logic [XW-1:0]       wr_x;
  logic [SPR-1:0]      wr_mask;
  logic [SPR*COLW-1:0] wr_col;
  logic                buf_hit;
  logic [COLW-1:0]     buf_col;

  spr_seq #(.NUM_OBJ(NUM_OBJ), .LINE_W(LINE_W), .WORDS(WORDS)) i_seq (
    .clk_i, .rst_ni, .line_start_i, .line_i,
    .obj_addr_o, .obj_data_i, .pat_addr_o, .pat_data_i, .pal_table_i,
    .busy_o,
    .draw_sel_o (draw_sel),
    .clr_en_o   (clr_en),
    .clr_idx_o  (clr_idx),
    .wr_en_o    (wr_en),
    .wr_x_o     (wr_x),
    .wr_mask_o  (wr_mask),
    .wr_col_o   (wr_col)
  );

  spr_line_buf #(.LINE_W(LINE_W), .WORDS(WORDS)) i_buf (
    .clk_i, .rst_ni,
    .draw_sel_i (draw_sel),
    .clr_en_i   (clr_en),
    .clr_idx_i  (clr_idx),
    .wr_en_i    (wr_en),
    .wr_x_i     (wr_x),
    .wr_mask_i  (wr_mask),
    .wr_col_i   (wr_col),
    .rd_x_i,
    .rd_hit_o   (buf_hit),
    .rd_col_o   (buf_col)
  );

  spr_out_mux i_mux (
    .spr_hit_i (buf_hit),
    .spr_col_i (buf_col),
    .bg_col_i  (bg_rgb_i),
    .rgb_o,
    .hit_o
  );
endmodule

// File: rtl/spr_checker.sv
module spr_checker #(
  parameter int unsigned NUM_OBJ = 512,
  parameter int unsigned LINE_W  = 640,
  localparam int unsigned OAW    = $clog2(NUM_OBJ)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           line_start_i,
  input logic           busy_o,
  input logic [OAW-1:0] obj_addr_o,
  input logic [9:0]     rd_x_i,
  input logic [7:0]     bg_rgb_i,
  input logic [7:0]     rgb_o,
  input logic           hit_o,
  input logic           clr_en,
  input logic           wr_en
);
  a_r11_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> busy_o);

  a_r11_addr_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(line_start_i)) |->
      (obj_addr_o == $past(obj_addr_o) || obj_addr_o == $past(obj_addr_o) + 1'b1));

  a_r11_no_idle_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en || wr_en) |-> busy_o);

  a_r9_clear_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> clr_en);

  a_r10_bg_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (rgb_o == bg_rgb_i));

  a_r8_no_hit_offscreen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_x_i >= 10'(LINE_W)) |-> !hit_o);
endmodule

bind sprite_line_composer spr_checker #(.NUM_OBJ(NUM_OBJ), .LINE_W(LINE_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_start_i (line_start_i),
  .busy_o       (busy_o),
  .obj_addr_o   (obj_addr_o),
  .rd_x_i       (rd_x_i),
  .bg_rgb_i     (bg_rgb_i),
  .rgb_o        (rgb_o),
  .hit_o        (hit_o),
  .clr_en       (clr_en),
  .wr_en        (wr_en)
);

// File: tb/test_sprite_line_composer.sv
module test_sprite_line_composer;
  localparam int NOBJ = 512;
  localparam int LW   = 640;
  localparam int NPAT = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic [8:0]  line_in = '0;
  logic        busy;
  logic [8:0]  obj_addr;
  logic [31:0] obj_data = '0;
  logic [9:0]  pat_addr;
  logic [31:0] pat_data = '0;
  logic [255:0] pal = '0;
  logic [9:0]  rd_x = '0;
  logic [7:0]  bg_rgb;
  logic [7:0]  rgb;
  logic        hit;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] obj_mem [NOBJ];
  logic [31:0] pat_mem [NPAT];
  logic        exp_hit [LW];
  logic [7:0]  exp_col [LW];
  logic        prev_hit [LW];
  logic [7:0]  prev_col [LW];
  int          exp_cover;

  always #5 clk = ~clk;

  assign bg_rgb = rd_x[7:0] ^ 8'hA5;

  always @(posedge clk) begin
    obj_data <= obj_mem[obj_addr];
    pat_data <= pat_mem[pat_addr];
  end

  sprite_line_composer i_sprite_line_composer (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(line_start), .line_i(line_in),
    .busy_o(busy), .obj_addr_o(obj_addr), .obj_data_i(obj_data),
    .pat_addr_o(pat_addr), .pat_data_i(pat_data), .pal_table_i(pal),
    .rd_x_i(rd_x), .bg_rgb_i(bg_rgb), .rgb_o(rgb), .hit_o(hit)
  );

  // reference model from R3..R8
  task automatic compute(input int line);
    exp_cover = 0;
    for (int x = 0; x < LW; x++) begin exp_hit[x] = 1'b0; exp_col[x] = '0; end
    for (int i = 0; i < NOBJ; i++) begin
      int ox, oy, op, opat, dy;
      logic [31:0] row;
      ox = int'(obj_mem[i][31:22]); oy = int'(obj_mem[i][21:13]);
      op = int'(obj_mem[i][12:10]); opat = int'(obj_mem[i][9:0]);
      dy = line - oy;
      if (dy >= 0 && dy < 16) begin
        exp_cover++;
        row = pat_mem[(opat + dy) % NPAT];
        for (int k = 0; k < 16; k++) begin
          int code;
          code = int'(row[2*k +: 2]);
          if (code != 0 && ox + k < LW) begin
            exp_hit[ox + k] = 1'b1;
            exp_col[ox + k] = pal[(op*4 + code)*8 +: 8];
          end
        end
      end
    end
  endtask

  task automatic save_prev();
    for (int x = 0; x < LW; x++) begin prev_hit[x] = exp_hit[x]; prev_col[x] = exp_col[x]; end
  endtask

  task automatic check_read(input string tag, input bit use_prev);
    int bad = 0;
    int bx = 0;
    logic [7:0] brgb = '0, bexp = '0;
    logic bh = 1'b0, beh = 1'b0;
    for (int x = 0; x < LW + 4; x++) begin
      logic eh;
      logic [7:0] ec;
      rd_x = 10'(x);
      #1;
      eh = (x < LW) ? (use_prev ? prev_hit[x] : exp_hit[x]) : 1'b0;
      ec = eh ? (use_prev ? prev_col[x] : exp_col[x]) : (8'(x) ^ 8'hA5);
      if ((hit !== eh || rgb !== ec) && bad == 0) begin
        bx = x; brgb = rgb; bh = hit; bexp = ec; beh = eh;
      end
      if (hit !== eh || rgb !== ec) bad++;
    end
    n_tests++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s: x=%0d rgb=%h hit=%b expected rgb=%h hit=%b (%0d bad pixels)",
               tag, bx, brgb, bh, bexp, beh, bad);
    end
  endtask

  task automatic start(input int line);
    @(negedge clk);
    line_start = 1'b1;
    line_in = 9'(line);
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // compose l, verify the old buffer, swap with l2, verify l
  task automatic scenario(input string tag, input int l, input int l2, input bit chk_time);
    int cyc, cov;
    compute(l);
    cov = exp_cover;
    start(l);
    wait_done(cyc);
    if (chk_time) check_int({tag, " R11 busy cycles"}, cyc, 160 + 2*NOBJ + cov);
    check_read({tag, " R2 previous buffer kept"}, 1'b1);
    start(l2);
    check_read(tag, 1'b0);
    compute(l2);
    wait_done(cyc);
    save_prev();
  endtask

  task automatic clear_objs();
    for (int i = 0; i < NOBJ; i++) obj_mem[i] = {10'd0, 9'd511, 3'd0, 10'd0};
  endtask

  task automatic put_obj(input int i, input int x, input int y, input int p, input int pat);
    obj_mem[i] = {10'(x), 9'(y), 3'(p), 10'(pat)};
  endtask

  task automatic rand_fill();
    for (int i = 0; i < NOBJ; i++) obj_mem[i] = $urandom;
    for (int i = 0; i < NPAT; i++) pat_mem[i] = $urandom;
    for (int i = 0; i < 8; i++) pal[32*i +: 32] = $urandom;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog expired: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    void'($urandom(32'd20240611));
    rand_fill();
    for (int x = 0; x < LW; x++) begin prev_hit[x] = 1'b0; prev_col[x] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_int("R1 busy after reset", int'(busy), 0);
    check_read("R1 empty buffers after reset", 1'b1);

    // R3 R4 R5 R7: random tables, several lines
    for (int t = 0; t < 3; t++) begin
      rand_fill();
      scenario("R3 R5 R7 random line", int'($urandom_range(0, 479)), int'($urandom_range(0, 479)), 1'b1);
    end

    // R6 R7: transparent codes let an earlier object show through
    clear_objs();
    for (int i = 0; i < 16; i++) begin pat_mem[i] = 32'h5555_5555; pat_mem[16+i] = 32'h0000_FFFF; end
    put_obj(0, 100, 200, 1, 0);
    put_obj(1, 104, 200, 6, 16);
    scenario("R6 R7 transparency and overlap", 205, 207, 1'b1);

    // R8: right-edge clipping, no wrap to x=0
    clear_objs();
    put_obj(3, 632, 10, 2, 0);
    put_obj(9, 1015, 10, 3, 0);
    put_obj(20, 630, 12, 4, 16);
    scenario("R8 right edge clip", 13, 12, 1'b1);

    // R4: vertical coverage boundaries and row selection
    rand_fill();
    clear_objs();
    put_obj(0, 0, 300, 0, 32);
    put_obj(1, 20, 316, 1, 48);
    put_obj(2, 40, 299, 2, 64);
    put_obj(3, 60, 315, 3, 80);
    put_obj(4, 80, 510, 4, 96);
    put_obj(5, 120, 305, 5, 1020);
    scenario("R4 coverage rows", 315, 5, 1'b1);

    // R9: reused buffer is cleared
    clear_objs();
    scenario("R9 clear before compose", 315, 5, 1'b1);

    // R12: restart during composition
    rand_fill();
    compute(77);
    start(77);
    repeat (50) @(negedge clk);
    start(333);
    wait_done(cyc);
    compute(333);
    check_int("R12 busy cycles after restart", cyc, 160 + 2*NOBJ + exp_cover);
    start(100);
    check_read("R12 restarted line", 1'b0);
    compute(100);
    wait_done(cyc);
    save_prev();
    rand_fill();
    scenario("R2 R10 random after restart", 450, 3, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule